// File: doc/BRIEF.md
# Serial ADC Result Reader

This block is the host side of a 32-bit serial link to a delta-sigma converter. When `start` is seen, it pulls the chip select low and watches the converter's data line. That line carries a real-time ready flag, which drops to zero when a conversion has finished. Once the flag is low, the reader clocks out 32 bits on a serial clock. It makes this clock by dividing the system clock, and it samples the data line on every rising edge. After the last edge it releases the chip select.

The captured word is checked and split into parts:
- an even-parity check over all 32 bits;
- a check that the always-zero second bit is in fact zero;
- a signed 24-bit conversion value built from the sign bit and the 23-bit magnitude;
- over-range and under-range flags taken from the sign/MSB pair;
- a 5-bit channel code.

All of these appear on a parallel output with a one-cycle strobe.

If the ready flag stays high too long, the wait is abandoned and a timeout is reported instead. Between reads the chip select is held high for at least one serial clock period.

Top module: `adc_word_reader`

## Requirements
- R1: A `start` seen while idle drives `cs_n` low on the next cycle and raises `busy`. A `start` seen while `busy` is high has no effect, so `cs_n` falls exactly once per read.
- R2: `sck` idles low and shows no rising edge while `cs_n` is high, or while the data line still shows the ready flag high after `cs_n` falls.
- R3: Each `sck` high or low phase lasts max(2, `half_div`) system clocks. The value is taken when the read starts.
- R4: Each completed read makes exactly 32 rising `sck` edges. The data line is captured on each one, first bit received as word bit 31, and the last bit (bit 0) on the 32nd rising edge.
- R5: After the 32nd pulse falls, `cs_n` goes high and `valid` pulses for exactly one cycle in that same cycle, with all decoded fields. The fields hold until the next `valid`.
- R6: `result` is the 24-bit two's complement value of word bits 29..6 with bit 29 inverted. Bit 29 = 1 gives a non-negative value equal to bits 28..6. Bit 29 = 0 gives bits 28..6 minus 2^23.
- R7: `over` is 1 when word bits 29 and 28 are both 1. `under` is 1 when both are 0.
- R8: `chan` equals word bits 5..1, with bit 5 as the MSB of `chan`.
- R9: `par_err` is 1 exactly when the 32-bit word holds an odd number of ones.
- R10: `frm_err` is 1 exactly when word bit 30 is 1.
- R11: If the ready flag is sampled high on `tmo_limit`+1 consecutive cycles of waiting, the read is abandoned. `cs_n` returns high, `timeout` pulses for one cycle, no `sck` edge is made and `valid` stays low.
- R12: After a read or a timeout, `cs_n` stays high for at least 2·max(2, `half_div`) system clocks before it can fall again. `busy` stays high throughout that gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one read |
| half_div | input | DIV_W | System clocks per serial clock half period (minimum 2 applied) |
| tmo_limit | input | TMO_W | Ready-wait limit in system clocks |
| sdo | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select |
| sck | output | 1 | Serial clock |
| busy | output | 1 | Read, wait or gap in progress |
| valid | output | 1 | One-cycle strobe for the decoded fields |
| result | output | 24 | Signed conversion value |
| over | output | 1 | Input above positive full scale |
| under | output | 1 | Input below negative full scale |
| chan | output | 5 | Channel code carried in the word |
| par_err | output | 1 | Parity of the word is odd |
| frm_err | output | 1 | Always-zero bit was found set |
| timeout | output | 1 | One-cycle pulse: ready wait abandoned |

## Verification
The assertions check the link-level rules on every cycle:
- the serial clock stays quiet while chip select is high;
- chip select is high whenever the block is idle;
- each release of chip select comes with either the data strobe or the timeout pulse;
- both strobes are single-cycle pulses.

Some behaviour can only be shown by the bench's scenarios, because it needs a model of the converter: the exact half-period length per divider setting, the 32-edge count, and no clocking before the ready flag drops. The same holds for the decoded field values, parity and framing detection, the range encodings, the timeout path and the minimum chip-select gap under back-to-back requests.

// File: rtl/adc_word_reader.sv
module adc_word_reader #(
  parameter int DIV_W = 8,
  parameter int TMO_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [DIV_W-1:0]   half_div,
  input  logic [TMO_W-1:0]   tmo_limit,
  input  logic               sdo,
  output logic               cs_n,
  output logic               sck,
  output logic               busy,
  output logic               valid,
  output logic signed [23:0] result,
  output logic               over,
  output logic               under,
  output logic [4:0]         chan,
  output logic               par_err,
  output logic               frm_err,
  output logic               timeout
);
  localparam int WORD = 32;
  localparam int BCW  = $clog2(WORD + 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_SHIFT, S_GAP} st_t;

  st_t              st;
  logic [DIV_W-1:0] half_q, hcnt;
  logic [BCW-1:0]   nbits;
  logic [WORD-1:0]  shreg;
  logic [TMO_W-1:0] tcnt;
  logic             gap_ph;

  wire [DIV_W-1:0] half_eff = (half_div < DIV_W'(2)) ? DIV_W'(2) : half_div;
  wire             tick     = (hcnt == half_q - 1'b1);

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cs_n    <= 1'b1;
      sck     <= 1'b0;
      half_q  <= DIV_W'(2);
      hcnt    <= '0;
      nbits   <= '0;
      shreg   <= '0;
      tcnt    <= '0;
      gap_ph  <= 1'b0;
      valid   <= 1'b0;
      timeout <= 1'b0;
      result  <= '0;
      over    <= 1'b0;
      under   <= 1'b0;
      chan    <= '0;
      par_err <= 1'b0;
      frm_err <= 1'b0;
    end else begin
      valid   <= 1'b0;
      timeout <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          half_q <= half_eff;
          cs_n   <= 1'b0;
          tcnt   <= '0;
          hcnt   <= '0;
          nbits  <= '0;
          st     <= S_WAIT;
        end
        S_WAIT: begin
          if (!sdo) begin
            hcnt <= '0;
            st   <= S_SHIFT;
          end else if (tcnt == tmo_limit) begin
            cs_n    <= 1'b1;
            timeout <= 1'b1;
            hcnt    <= '0;
            gap_ph  <= 1'b0;
            st      <= S_GAP;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        S_SHIFT: begin
          if (tick) begin
            hcnt <= '0;
            sck  <= ~sck;
            if (!sck) begin
              shreg <= {shreg[WORD-2:0], sdo};
              nbits <= nbits + 1'b1;
            end else if (nbits == BCW'(WORD)) begin
              cs_n    <= 1'b1;
              valid   <= 1'b1;
              result  <= {~shreg[29], shreg[28:6]};
              over    <= shreg[29] & shreg[28];
              under   <= ~shreg[29] & ~shreg[28];
              chan    <= shreg[5:1];
              par_err <= ^shreg;
              frm_err <= shreg[30];
              gap_ph  <= 1'b0;
              st      <= S_GAP;
            end
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        S_GAP: begin
          if (tick) begin
            hcnt <= '0;
            if (gap_ph) st <= S_IDLE;
            else        gap_ph <= 1'b1;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module adc_word_reader_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sck,
  input logic busy,
  input logic valid,
  input logic timeout
);
  // R2
  sck_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sck);
  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) valid |=> !valid);
  // R5
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_n) |-> (valid || timeout));
  // R11
  tmo_abort_chk: assert property (@(posedge clk) disable iff (!rst_n) timeout |-> (cs_n && !valid));
  // R11
  tmo_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) timeout |=> !timeout);
  // R12
  idle_cs_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> cs_n);
endmodule

bind adc_word_reader adc_word_reader_chk u_chk (.*);

// File: tb/test_adc_word_reader.sv
module test_adc_word_reader;
  logic clk = 0, rst_n = 0, start = 0, sdo = 1;
  logic [7:0]  half_div = 8'd2;
  logic [15:0] tmo_limit = 16'd300;
  logic cs_n, sck, busy, valid, over, under, par_err, frm_err, timeout;
  logic signed [23:0] result;
  logic [4:0] chan;

  adc_word_reader i_adc_word_reader (.*);

  always #2.5 clk = ~clk;

  int errors = 0, checks = 0;
  logic [31:0] word;
  int delay, idx, wcnt, exp_half;
  bit ready, prev_sck, prev_cs;
  int rises, early_rises, bad_iv, iv, cs_falls, hi_run, min_gap;
  bit seen_read;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model and link monitor
  always @(negedge clk) begin
    if (!cs_n && !prev_cs) begin
      if (prev_sck && !sck) idx++;
    end
    if (cs_n) begin
      wcnt = 0; idx = 0; ready = 0; sdo = 1;
      hi_run++;
    end else begin
      if (prev_cs && seen_read) begin
        if (hi_run < min_gap) min_gap = hi_run;
      end
      hi_run = 0;
      if (prev_cs) cs_falls++;
      if (wcnt >= delay) ready = 1; else wcnt++;
      sdo = ready ? ((idx < 32) ? word[31 - idx] : 1'b1) : 1'b1;
    end
    if (sck !== prev_sck) begin
      if (iv != exp_half) bad_iv++;
      iv = 1;
      if (sck) begin
        rises++;
        if (!ready) early_rises++;
      end
    end else iv++;
    prev_sck = sck;
    prev_cs = cs_n;
  end

  function automatic logic [31:0] make_word(input logic [22:0] mag, input bit sg, input bit dmy,
                                            input logic [4:0] ch, input bit bad_par);
    logic [31:0] w;
    w = {1'b0, dmy, sg, mag, ch, 1'b0};
    w[0] = (^w[31:1]) ^ bad_par;
    return w;
  endfunction

  function automatic int exp_value(input logic [31:0] w);
    int m;
    m = int'(w[28:6]);
    return w[29] ? m : m - (1 << 23);
  endfunction

  task automatic do_read(input logic [31:0] w, input int dly, input int hd, input bit expect_tmo);
    int n;
    bit got_v, got_t;
    word = w; delay = dly; half_div = 8'(hd);
    exp_half = (hd < 2) ? 2 : hd;
    rises = 0; early_rises = 0; bad_iv = 0; iv = 0; cs_falls = 0;
    @(negedge clk); start = 1;
    @(negedge clk);
    // R1
    chk(!cs_n && busy, "R1", {cs_n, busy}, 2'b01);
    n = 0; got_v = 0; got_t = 0;
    while (!valid && !timeout && n < 20000) begin @(negedge clk); n++; end
    got_v = valid; got_t = timeout;
    start = 0;
    if (n >= 20000) chk(0, "watchdog", n, 0);
    if (expect_tmo) begin
      // R11
      chk(got_t && !got_v && cs_n, "R11", {got_t, got_v, cs_n}, 3'b101);
      chk(rises == 0, "R11", rises, 0);
    end else begin
      chk(got_v && cs_n, "R5", {got_v, cs_n}, 2'b11);
      // R4
      chk(rises == 32, "R4", rises, 32);
      // R2
      chk(early_rises == 0, "R2", early_rises, 0);
      // R3
      chk(bad_iv <= 1, "R3", bad_iv, 1);
      // R6
      chk(int'(result) == exp_value(w), "R6", result, exp_value(w));
      // R7
      chk(over == (w[29] & w[28]) && under == (!w[29] && !w[28]), "R7", {over, under}, {w[29] & w[28], !w[29] & !w[28]});
      // R8
      chk(chan == w[5:1], "R8", chan, w[5:1]);
      // R9
      chk(par_err == ^w, "R9", par_err, ^w);
      // R10
      chk(frm_err == w[30], "R10", frm_err, w[30]);
      @(negedge clk);
      chk(!valid, "R5", valid, 0);
    end
    // R1: start held during the read caused only one chip-select fall
    chk(cs_falls == 1, "R1", cs_falls, 1);
    while (busy) @(negedge clk);
    seen_read = 1;
  endtask

  initial begin
    hi_run = 0; min_gap = 1 << 30; seen_read = 0; prev_sck = 0; prev_cs = 1;
    word = 0; delay = 0; exp_half = 2;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(cs_n && !sck && !busy && !valid && !timeout, "R12", {cs_n, sck, busy, valid, timeout}, 5'b10000);
    rst_n = 1;
    void'($urandom(32'd1234));
    // directed: over-range, under-range, zero half divider, one, parity and framing faults
    do_read(make_word(23'h7FFFFF, 1, 0, 5'd17, 0), 5, 0, 0);
    do_read(make_word(23'h000000, 0, 0, 5'd3, 0), 0, 1, 0);
    do_read(make_word(23'h400001, 1, 0, 5'd31, 1), 12, 3, 0);
    do_read(make_word(23'h12345, 0, 1, 5'd0, 0), 7, 4, 0);
    do_read(make_word(23'h555555, 1, 0, 5'd9, 0), 5000, 2, 1);
    for (int k = 0; k < 20; k++) begin
      int hd;
      hd = int'($urandom_range(0, 5));
      do_read(make_word(23'($urandom), 1'($urandom), ($urandom_range(0, 7) == 0),
                        5'($urandom), ($urandom_range(0, 5) == 0)),
              int'($urandom_range(0, 40)), hd, 0);
      // R12
      chk(min_gap >= 2 * 5 || min_gap >= 2 * exp_half || min_gap >= 4, "R12", min_gap, 4);
    end
    // R12: gap with a large divider, back-to-back
    do_read(make_word(23'h0F0F0F, 1, 0, 5'd5, 0), 2, 6, 0);
    min_gap = 1 << 30;
    do_read(make_word(23'h0F0F0E, 0, 0, 5'd6, 0), 2, 6, 0);
    chk(min_gap >= 12, "R12", min_gap, 12);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule